// File: doc/BRIEF.md
# BCD Time-of-Day Register Bank

This block keeps calendar time in eight byte-wide registers at the top of a byte-addressed map. The registers are control, seconds, minutes, hours, weekday with a century flag, date, month and year. Every time field is stored as packed BCD. A one-cycle `tick` pulse, expected once per second, moves the time forward. Carries ripple from seconds up to years and follow the length of each month, including February in leap years.

Software reaches the bank through a plain synchronous port. A write lands on the clock edge where `wr_en` is high. A read returns data one cycle after the address is presented. Each write is checked against the legal range of its field, and a value out of range is dropped without any signal. Bit 7 of the seconds register is a stop flag that freezes counting. The control register always holds two forced-high bits and one forced-low bit. The year-base parameter gives the calendar epoch used by the leap-year rule.

Top module: `bcd_rtc_regs`

## Requirements
- R1: After reset the bank reads control 0x90, seconds 0x00, minutes 0x00, hours 0x00, weekday register 0x01, date 0x01, month 0x01, year 0x00, with the stop flag clear.
- R2: The window holds the eight addresses whose upper bits are all ones. Offset 0 is control, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month and 7 year. Read data appears on the cycle after the address. Seconds read as {stop, seconds[6:0]}. The weekday register reads as century in bit 6 and weekday in bits 2:0. An address outside the window reads 0x00.
- R3: Each accepted tick adds one second. Seconds wrap 59 to 00 into minutes, minutes wrap 59 to 00 into hours, and hours wrap 23 to 00 into the date. With no tick and no write, the time fields hold.
- R4: The date wraps to 01 after 28, 29, 30 or 31 according to the month. February has 29 days when (epoch + year) is divisible by 4. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R5: The weekday steps on every date advance, and 7 wraps to 1. A write to offset 4 stores bits 2:0 as the weekday and bit 6 as the century flag. The century flag survives weekday stepping.
- R6: While the stop flag is set, ticks are ignored. Clearing the flag resumes counting from the frozen value.
- R7: A seconds write always updates the stop flag from bit 7. Bits 6:0 are applied only when they form legal BCD in 00..59.
- R8: A minutes write applies bits 6:0 only when they form legal BCD in 00..59. An hours write applies bits 5:0 only when they form legal BCD in 00..23.
- R9: A date write applies bits 5:0 only when they form legal BCD in 01..31, so 0 is ignored. A month write applies bits 4:0 only when they form legal BCD in 01..12.
- R10: A year write applies the full byte only when it forms legal BCD in 00..99.
- R11: A control write stores (data & ~0xA0) | 0x90.
- R12: A write to an address outside the window changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse that advances time by one second |
| addr | input | ADDR_W | Byte address for both read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data for the previous cycle's address |

## Verification
The bench builds the bank with an 11-bit address, which places the window at 0x7F8..0x7FF. Addresses 0x7F7 and 0x000 then sit just outside the window and are used to show that stray writes change nothing. The epoch is set to 1968, so years 04 and 03 give one leap February and one plain February. The bench also covers the end of a 30-day month and the year 99 to 00 wrap, and walks the weekday through its 7-to-1 wrap while the century flag is set.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

    localparam int NUM_TF = 6;

    // Index of each time field in the carry chain (low to high).
    localparam int TF_SEC  = 0;
    localparam int TF_MIN  = 1;
    localparam int TF_HOUR = 2;
    localparam int TF_DATE = 3;
    localparam int TF_MON  = 4;
    localparam int TF_YEAR = 5;

    typedef enum logic [2:0] {
        OFF_CTRL = 3'd0,
        OFF_SEC  = 3'd1,
        OFF_MIN  = 3'd2,
        OFF_HOUR = 3'd3,
        OFF_WDAY = 3'd4,
        OFF_DATE = 3'd5,
        OFF_MON  = 3'd6,
        OFF_YEAR = 3'd7
    } reg_off_e;

    typedef struct packed {
        logic [7:0]             ctrl;
        logic                   stop;
        logic [2:0]             wday;
        logic                   cent;
        logic [NUM_TF-1:0][7:0] tf;
        logic [7:0]             rd;
    } rtc_state_t;

    localparam rtc_state_t RTC_RESET = '{
        ctrl: 8'h90,
        stop: 1'b0,
        wday: 3'd1,
        cent: 1'b0,
        tf:   {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00},
        rd:   8'h00
    };

    function automatic logic bcd_in_range(input logic [7:0] v,
                                          input logic [7:0] lo,
                                          input logic [7:0] hi);
        return (v[3:0] <= 4'd9) && (v >= lo) && (v <= hi);
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) begin
            return {v[7:4] + 4'd1, 4'd0};
        end
        return v + 8'd1;
    endfunction

    function automatic logic leap_year(input logic [7:0] yr, input int epoch);
        int y;
        y = int'(yr[7:4]) * 10 + int'(yr[3:0]) + epoch;
        return (y % 4) == 0;
    endfunction

    function automatic logic [7:0] month_days(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/bcd_rtc_step.sv
module bcd_rtc_step (
    input  logic [7:0] cur,
    input  logic [7:0] lo,
    input  logic [7:0] hi,
    input  logic       en,
    output logic [7:0] nxt,
    output logic       wrap
);
    import bcd_rtc_pkg::*;

    always_comb begin
        nxt  = cur;
        wrap = 1'b0;
        if (en) begin
            if (cur >= hi) begin
                nxt  = lo;
                wrap = 1'b1;
            end else begin
                nxt = bcd_inc(cur);
            end
        end
    end
endmodule

// File: rtl/bcd_rtc_advance.sv
module bcd_rtc_advance #(
    parameter int EPOCH_YEAR = 1900
) (
    input  logic [bcd_rtc_pkg::NUM_TF-1:0][7:0] tf_cur,
    input  logic                                en,
    output logic [bcd_rtc_pkg::NUM_TF-1:0][7:0] tf_nxt,
    output logic                                day_step
);
    import bcd_rtc_pkg::*;

    logic [NUM_TF-1:0][7:0] lo_v;
    logic [NUM_TF-1:0][7:0] hi_v;
    logic [NUM_TF-1:0]      step_en;
    logic [NUM_TF-1:0]      wraps;
    logic                   unused_year_wrap;

    always_comb begin
        lo_v[TF_SEC]  = 8'h00;  hi_v[TF_SEC]  = 8'h59;
        lo_v[TF_MIN]  = 8'h00;  hi_v[TF_MIN]  = 8'h59;
        lo_v[TF_HOUR] = 8'h00;  hi_v[TF_HOUR] = 8'h23;
        lo_v[TF_DATE] = 8'h01;
        hi_v[TF_DATE] = month_days(tf_cur[TF_MON], leap_year(tf_cur[TF_YEAR], EPOCH_YEAR));
        lo_v[TF_MON]  = 8'h01;  hi_v[TF_MON]  = 8'h12;
        lo_v[TF_YEAR] = 8'h00;  hi_v[TF_YEAR] = 8'h99;
    end

    assign step_en = {wraps[NUM_TF-2:0], en};

    for (genvar g = 0; g < NUM_TF; g++) begin : g_field
        bcd_rtc_step u_step (
            .cur  (tf_cur[g]),
            .lo   (lo_v[g]),
            .hi   (hi_v[g]),
            .en   (step_en[g]),
            .nxt  (tf_nxt[g]),
            .wrap (wraps[g])
        );
    end

    assign day_step         = step_en[TF_DATE];
    assign unused_year_wrap = wraps[NUM_TF-1];
endmodule

// File: rtl/bcd_rtc_decode.sv
module bcd_rtc_decode #(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [7:0]                 wr_data,
    output logic                       hit,
    output bcd_rtc_pkg::reg_off_e      off,
    output logic                       legal
);
    import bcd_rtc_pkg::*;

    assign hit = &addr[ADDR_W-1:3];
    assign off = reg_off_e'(addr[2:0]);

    always_comb begin
        unique case (off)
            OFF_SEC,
            OFF_MIN:  legal = bcd_in_range({1'b0, wr_data[6:0]}, 8'h00, 8'h59);
            OFF_HOUR: legal = bcd_in_range({2'b0, wr_data[5:0]}, 8'h00, 8'h23);
            OFF_DATE: legal = bcd_in_range({2'b0, wr_data[5:0]}, 8'h01, 8'h31);
            OFF_MON:  legal = bcd_in_range({3'b0, wr_data[4:0]}, 8'h01, 8'h12);
            OFF_YEAR: legal = bcd_in_range(wr_data, 8'h00, 8'h99);
            OFF_CTRL,
            OFF_WDAY: legal = 1'b1;
        endcase
    end
endmodule

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs #(
    parameter int ADDR_W     = 13,
    parameter int EPOCH_YEAR = 1900
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data
);
    import bcd_rtc_pkg::*;

    rtc_state_t             q, d;
    logic                   hit;
    reg_off_e               off;
    logic                   legal;
    logic [NUM_TF-1:0][7:0] tf_adv;
    logic                   day_step;
    logic                   wr_hit;

    bcd_rtc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (addr),
        .wr_data (wr_data),
        .hit     (hit),
        .off     (off),
        .legal   (legal)
    );

    bcd_rtc_advance #(.EPOCH_YEAR(EPOCH_YEAR)) u_adv (
        .tf_cur   (q.tf),
        .en       (tick && !q.stop),
        .tf_nxt   (tf_adv),
        .day_step (day_step)
    );

    assign wr_hit = wr_en && hit;

    always_comb begin
        d    = q;
        d.tf = tf_adv;
        if (day_step) begin
            d.wday = (q.wday == 3'd7 || q.wday == 3'd0) ? 3'd1 : q.wday + 3'd1;
        end

        // A write overrides only the field it targets; carries from the
        // same cycle's tick still reach the other fields.
        if (wr_hit) begin
            unique case (off)
                OFF_CTRL: d.ctrl = (wr_data & ~8'hA0) | 8'h90;
                OFF_SEC: begin
                    d.stop = wr_data[7];
                    if (legal) d.tf[TF_SEC] = {1'b0, wr_data[6:0]};
                end
                OFF_MIN:  if (legal) d.tf[TF_MIN]  = {1'b0, wr_data[6:0]};
                OFF_HOUR: if (legal) d.tf[TF_HOUR] = {2'b0, wr_data[5:0]};
                OFF_WDAY: begin
                    d.wday = wr_data[2:0];
                    d.cent = wr_data[6];
                end
                OFF_DATE: if (legal) d.tf[TF_DATE] = {2'b0, wr_data[5:0]};
                OFF_MON:  if (legal) d.tf[TF_MON]  = {3'b0, wr_data[4:0]};
                OFF_YEAR: if (legal) d.tf[TF_YEAR] = wr_data;
            endcase
        end

        d.rd = 8'h00;
        if (hit) begin
            unique case (off)
                OFF_CTRL: d.rd = q.ctrl;
                OFF_SEC:  d.rd = {q.stop, q.tf[TF_SEC][6:0]};
                OFF_MIN:  d.rd = q.tf[TF_MIN];
                OFF_HOUR: d.rd = q.tf[TF_HOUR];
                OFF_WDAY: d.rd = {1'b0, q.cent, 3'b000, q.wday};
                OFF_DATE: d.rd = q.tf[TF_DATE];
                OFF_MON:  d.rd = q.tf[TF_MON];
                OFF_YEAR: d.rd = q.tf[TF_YEAR];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RTC_RESET;
        else        q <= d;
    end

    assign rd_data = q.rd;
endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tick,
    input logic                    wr_en,
    input bcd_rtc_pkg::rtc_state_t st
);
    // R7
    sec_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st.tf[0][3:0] <= 4'd9 && st.tf[0] <= 8'h59);

    // R9
    month_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st.tf[4] >= 8'h01 && st.tf[4] <= 8'h12);

    // R4
    date_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st.tf[3] >= 8'h01 && st.tf[3] <= 8'h31);

    // R11
    ctrl_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st.ctrl[7] && st.ctrl[4] && !st.ctrl[5]);

    // R6
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st.stop && !wr_en) |=> $stable(st.tf));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(st.tf));

    // R5
    wday_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> ($stable(st.wday) || !$stable(st.tf[3])));
endmodule

bind bcd_rtc_regs bcd_rtc_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .wr_en (wr_en),
    .st    (q)
);

// File: tb/bcd_rtc_regs_bench.sv
`timescale 1ns/1ps
module bcd_rtc_regs_bench;
    localparam int AW    = 11;
    localparam int EPOCH = 1968;
    localparam logic [AW-1:0] BASE = {{(AW-3){1'b1}}, 3'b000};

    localparam logic [1:0] OP_W = 2'd0; // write val to offset
    localparam logic [1:0] OP_R = 2'd1; // read offset, expect val
    localparam logic [1:0] OP_T = 2'd2; // val ticks
    localparam logic [1:0] OP_M = 2'd3; // set 23:59:59, stop clear

    typedef struct packed {
        logic [1:0] op;
        logic [2:0] off;
        logic [7:0] val;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 78;
    localparam vec_t VEC [NV] = '{
        '{OP_W, 3'd0, 8'hFF, 4'd11}, '{OP_R, 3'd0, 8'hDF, 4'd11}, // R11
        '{OP_W, 3'd0, 8'h00, 4'd11}, '{OP_R, 3'd0, 8'h90, 4'd11}, // R11
        '{OP_W, 3'd1, 8'h45, 4'd7},  '{OP_R, 3'd1, 8'h45, 4'd7},  // R7
        '{OP_W, 3'd1, 8'h60, 4'd7},  '{OP_R, 3'd1, 8'h45, 4'd7},  // R7
        '{OP_W, 3'd1, 8'h5A, 4'd7},  '{OP_R, 3'd1, 8'h45, 4'd7},  // R7
        '{OP_W, 3'd1, 8'hC5, 4'd6},  '{OP_R, 3'd1, 8'hC5, 4'd6},  // R6
        '{OP_T, 3'd0, 8'h03, 4'd6},  '{OP_R, 3'd1, 8'hC5, 4'd6},  // R6
        '{OP_W, 3'd1, 8'h7A, 4'd7},  '{OP_R, 3'd1, 8'h45, 4'd7},  // R7
        '{OP_T, 3'd0, 8'h02, 4'd6},  '{OP_R, 3'd1, 8'h47, 4'd6},  // R6
        '{OP_W, 3'd2, 8'h60, 4'd8},  '{OP_R, 3'd2, 8'h00, 4'd8},  // R8
        '{OP_W, 3'd2, 8'h59, 4'd8},  '{OP_R, 3'd2, 8'h59, 4'd8},  // R8
        '{OP_W, 3'd3, 8'h24, 4'd8},  '{OP_R, 3'd3, 8'h00, 4'd8},  // R8
        '{OP_W, 3'd3, 8'h23, 4'd8},  '{OP_R, 3'd3, 8'h23, 4'd8},  // R8
        '{OP_W, 3'd1, 8'h58, 4'd3},  '{OP_T, 3'd0, 8'h02, 4'd3},  // R3
        '{OP_R, 3'd1, 8'h00, 4'd3},  '{OP_R, 3'd2, 8'h00, 4'd3},  // R3
        '{OP_R, 3'd3, 8'h00, 4'd3},  '{OP_R, 3'd5, 8'h02, 4'd3},  // R3
        '{OP_R, 3'd4, 8'h02, 4'd5},                               // R5
        '{OP_W, 3'd5, 8'h00, 4'd9},  '{OP_R, 3'd5, 8'h02, 4'd9},  // R9
        '{OP_W, 3'd6, 8'h13, 4'd9},  '{OP_R, 3'd6, 8'h01, 4'd9},  // R9
        '{OP_W, 3'd6, 8'h00, 4'd9},  '{OP_R, 3'd6, 8'h01, 4'd9},  // R9
        '{OP_W, 3'd7, 8'h9A, 4'd10}, '{OP_R, 3'd7, 8'h00, 4'd10}, // R10
        '{OP_W, 3'd7, 8'hA0, 4'd10}, '{OP_R, 3'd7, 8'h00, 4'd10}, // R10
        '{OP_W, 3'd4, 8'h47, 4'd2},  '{OP_R, 3'd4, 8'h47, 4'd2},  // R2
        // leap February (1972)
        '{OP_W, 3'd7, 8'h04, 4'd4},  '{OP_W, 3'd6, 8'h02, 4'd4},  // R4
        '{OP_W, 3'd5, 8'h28, 4'd4},  '{OP_M, 3'd0, 8'h00, 4'd4},  // R4
        '{OP_T, 3'd0, 8'h01, 4'd4},  '{OP_R, 3'd5, 8'h29, 4'd4},  // R4
        '{OP_R, 3'd6, 8'h02, 4'd4},  '{OP_R, 3'd4, 8'h41, 4'd5},  // R4 R5
        '{OP_M, 3'd0, 8'h00, 4'd4},  '{OP_T, 3'd0, 8'h01, 4'd4},  // R4
        '{OP_R, 3'd5, 8'h01, 4'd4},  '{OP_R, 3'd6, 8'h03, 4'd4},  // R4
        // plain February (1971)
        '{OP_W, 3'd7, 8'h03, 4'd4},  '{OP_W, 3'd6, 8'h02, 4'd4},  // R4
        '{OP_W, 3'd5, 8'h28, 4'd4},  '{OP_M, 3'd0, 8'h00, 4'd4},  // R4
        '{OP_T, 3'd0, 8'h01, 4'd4},  '{OP_R, 3'd5, 8'h01, 4'd4},  // R4
        '{OP_R, 3'd6, 8'h03, 4'd4},                               // R4
        // 30-day month
        '{OP_W, 3'd6, 8'h04, 4'd4},  '{OP_W, 3'd5, 8'h30, 4'd4},  // R4
        '{OP_M, 3'd0, 8'h00, 4'd4},  '{OP_T, 3'd0, 8'h01, 4'd4},  // R4
        '{OP_R, 3'd5, 8'h01, 4'd4},  '{OP_R, 3'd6, 8'h05, 4'd4},  // R4
        // year wrap
        '{OP_W, 3'd7, 8'h99, 4'd4},  '{OP_W, 3'd6, 8'h12, 4'd4},  // R4
        '{OP_W, 3'd5, 8'h31, 4'd4},  '{OP_M, 3'd0, 8'h00, 4'd4},  // R4
        '{OP_T, 3'd0, 8'h01, 4'd4},  '{OP_R, 3'd7, 8'h00, 4'd4},  // R4
        '{OP_R, 3'd6, 8'h01, 4'd4},  '{OP_R, 3'd5, 8'h01, 4'd4}   // R4
    };

    localparam logic [7:0] RST_EXP [8] = '{8'h90, 8'h00, 8'h00, 8'h00,
                                           8'h01, 8'h01, 8'h01, 8'h00};
    localparam logic [7:0] END_EXP [8] = '{8'h90, 8'h00, 8'h00, 8'h00,
                                           8'h45, 8'h01, 8'h01, 8'h00};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = 8'h00;
    logic [7:0]    rd_data;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2 clk = ~clk;

    bcd_rtc_regs #(.ADDR_W(AW), .EPOCH_YEAR(EPOCH)) u_bcd_rtc_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; wr_data = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic do_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input int req);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic read_check(input logic [AW-1:0] a, input logic [7:0] exp, input int req);
        logic [7:0] v;
        do_read(a, v);
        check(v, exp, req);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R3: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int i = 0; i < 8; i++) read_check(BASE + AW'(i), RST_EXP[i], 1);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_W: do_write(BASE + AW'(VEC[i].off), VEC[i].val);
                OP_R: read_check(BASE + AW'(VEC[i].off), VEC[i].val, int'(VEC[i].req));
                OP_T: do_ticks(int'(VEC[i].val));
                OP_M: begin
                    do_write(BASE + AW'(3), 8'h23);
                    do_write(BASE + AW'(2), 8'h59);
                    do_write(BASE + AW'(1), 8'h59);
                end
            endcase
        end

        // R12: writes just below the window and at address zero touch nothing
        do_write(BASE - AW'(1), 8'h55);
        do_write('0, 8'h12);
        // R2: unmapped address reads zero
        read_check(BASE - AW'(1), 8'h00, 2);
        for (int i = 0; i < 8; i++) read_check(BASE + AW'(i), END_EXP[i], 12);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule